// File: doc/BRIEF.md
# Multi-Channel Countdown PWM Generator

This block drives several pulse-width-modulated outputs, one bit per channel. Each channel is programmed with a period and a high-time, both given as counts of clock cycles. The high-time must not exceed the period. Each channel has its own down-counter and level register. The counter is loaded with the length of the current phase and counts down once per clock. When the phase expires, the level flips and the counter is loaded with the length of the opposite phase. No counter is shared between channels, so a change on one channel cannot shift the edges of another.

Settings are sampled only at the boundary of a complete period. Software can therefore rewrite a channel's period or high-time at any moment without producing a shortened or stretched pulse. Some settings are rejected: a zero period, a zero high-time, or a high-time larger than the period. A rejected setting parks the output low and raises a per-channel flag. A high-time equal to the period keeps the output high without interruption. Each channel has a synchronous restart input that returns it to its start-up state. A chip-level asynchronous reset clears all channels. At a 100 MHz clock, a period of 5000 cycles gives the 20 kHz rate these outputs usually run at.

Top module: `pwm_multi_cd`

## Requirements
- R1: With a valid setting, a channel's output stays high for exactly `duty` cycles and then low for exactly `period - duty` cycles, repeating.
- R2: A channel's level changes only on the clock edge where its active phase count expires. While the channel is running, its remaining count is never zero.
- R3: A setting is invalid if period = 0, duty = 0 or duty > period. An invalid setting holds that channel's output low and sets its `cfg_bad_o` bit, and the output never toggles.
- R4: When duty equals period, the output stays high without any low cycle.
- R5: New period and duty values take effect only at the end of a complete period. A change made in the middle of a period does not alter that period's high or low length.
- R6: Channels are independent. Changing or restarting one channel leaves the waveform of every other channel unchanged.
- R7: While `ch_restart_i` of a channel is high, its output is low from the next edge on. The first edge with restart low samples the setting and, if the setting is valid, starts the high phase.
- R8: While `arst_ni` is low, every output and every `cfg_bad_o` bit is low. After release, the internal reset ends on the second rising clock edge, and channels sample their settings on the third.
- R9: A channel parked by an invalid setting samples its inputs on every edge. On the first edge that sees a valid setting, it begins a high phase.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| arst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ch_restart_i | input | NUM_CH | Per-channel synchronous restart, active high |
| period_i | input | NUM_CH*CNT_W | Period in cycles per channel; channel n at bits [n*CNT_W +: CNT_W] |
| duty_i | input | NUM_CH*CNT_W | High-time in cycles per channel, same packing |
| pwm_o | output | NUM_CH | PWM output, one bit per channel |
| cfg_bad_o | output | NUM_CH | Set while the sampled setting of a channel is invalid |

## Verification
Two events can land on the same edge: the expiry of a period and the sampling of a new setting, since the next period's length is taken on the edge that closes the old one. The bench rewrites period and high-time while a high phase is in progress. It then measures the remaining high and low runs of the old setting, followed by the first runs of the new one. Any early pickup, late pickup or off-by-one at that shared edge shows up as a wrong run length. A second overlap is tested by changing and restarting a neighbouring channel in the same cycle in which a measured channel is mid-period. The measured channel's run lengths must come out exact.

// File: rtl/pwm_pkg.sv
package pwm_pkg;

  typedef enum logic {
    PH_LOW  = 1'b0,
    PH_HIGH = 1'b1
  } pwm_phase_e;

  localparam int unsigned PWM_CNT_W_DEF = 16;
  localparam int unsigned PWM_NUM_CH_DEF = 4;

endpackage

// File: rtl/pwm_rst_sync.sv
module pwm_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic arst_ni,
  output logic rst_no
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge arst_ni) begin
    if (!arst_ni) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_no = sync_q[STAGES-1];

endmodule

// File: rtl/pwm_cfg_check.sv
module pwm_cfg_check #(
  parameter int unsigned CNT_W = 16
) (
  input  logic [CNT_W-1:0] period_i,
  input  logic [CNT_W-1:0] duty_i,
  output logic             ok_o,
  output logic [CNT_W-1:0] hi_len_o,
  output logic [CNT_W-1:0] lo_len_o
);

  logic per_zero;
  logic duty_zero;
  logic duty_over;

  always_comb begin
    per_zero  = (period_i == '0);
    duty_zero = (duty_i == '0);
    duty_over = (duty_i > period_i);
    ok_o      = !per_zero && !duty_zero && !duty_over;
    hi_len_o  = duty_i;
    lo_len_o  = period_i - duty_i;
  end

endmodule

// File: rtl/pwm_cfg_shadow.sv
module pwm_cfg_shadow #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             restart_i,
  input  logic             load_i,
  input  logic             new_ok_i,
  input  logic [CNT_W-1:0] new_lo_i,
  output logic [CNT_W-1:0] cur_lo_o,
  output logic             bad_o
);

  logic [CNT_W-1:0] lo_q, lo_d;
  logic             bad_q, bad_d;
  logic             upd_en;

  always_comb begin
    upd_en = restart_i || load_i;
    lo_d   = lo_q;
    bad_d  = bad_q;
    if (restart_i) begin
      lo_d  = '0;
      bad_d = 1'b0;
    end else if (load_i) begin
      lo_d  = new_lo_i;
      bad_d = !new_ok_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lo_q  <= '0;
      bad_q <= 1'b0;
    end else if (upd_en) begin
      lo_q  <= lo_d;
      bad_q <= bad_d;
    end
  end

  assign cur_lo_o = lo_q;
  assign bad_o    = bad_q;

  // R5: the latched low length only moves on a period-boundary load or a restart
  assert_lo_held_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !restart_i) |=> $stable(lo_q));

endmodule

// File: rtl/pwm_phase_cnt.sv
module pwm_phase_cnt
  import pwm_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             restart_i,
  input  logic             new_ok_i,
  input  logic [CNT_W-1:0] new_hi_i,
  input  logic [CNT_W-1:0] cur_lo_i,
  output logic             load_o,
  output logic             level_o
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  pwm_phase_e       lvl_q, lvl_d;
  logic [CNT_W-1:0] rem_q, rem_d;
  logic             run_q, run_d;
  logic             expire;
  logic             period_end;
  logic             upd_en;

  always_comb begin
    expire     = run_q && (rem_q == ONE);
    period_end = expire && ((lvl_q == PH_LOW) || (cur_lo_i == '0));
    load_o     = !restart_i && (!run_q || period_end);
    upd_en     = restart_i || load_o || run_q;

    lvl_d = lvl_q;
    rem_d = rem_q;
    run_d = run_q;
    if (restart_i) begin
      lvl_d = PH_LOW;
      rem_d = '0;
      run_d = 1'b0;
    end else if (load_o) begin
      if (new_ok_i) begin
        lvl_d = PH_HIGH;
        rem_d = new_hi_i;
        run_d = 1'b1;
      end else begin
        lvl_d = PH_LOW;
        rem_d = '0;
        run_d = 1'b0;
      end
    end else if (expire) begin
      lvl_d = PH_LOW;
      rem_d = cur_lo_i;
    end else begin
      rem_d = rem_q - ONE;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lvl_q <= PH_LOW;
      rem_q <= '0;
      run_q <= 1'b0;
    end else if (upd_en) begin
      lvl_q <= lvl_d;
      rem_q <= rem_d;
      run_q <= run_d;
    end
  end

  assign level_o = (lvl_q == PH_HIGH);

  // R2: a running channel never holds a zero remaining count
  assert_rem_nonzero_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q |-> (rem_q != '0));

  // R2: a level change while running happens only at phase expiry
  assert_toggle_at_expiry_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$stable(lvl_q) && !$past(restart_i) && $past(run_q)) |-> ($past(rem_q) == ONE));

  // R7: restart forces the output low on the next edge
  assert_restart_low_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_i |=> !level_o);

endmodule

// File: rtl/pwm_multi_cd.sv
module pwm_multi_cd
  import pwm_pkg::*;
#(
  parameter int unsigned NUM_CH = PWM_NUM_CH_DEF,
  parameter int unsigned CNT_W  = PWM_CNT_W_DEF
) (
  input  logic                    clk_i,
  input  logic                    arst_ni,
  input  logic [NUM_CH-1:0]       ch_restart_i,
  input  logic [NUM_CH*CNT_W-1:0] period_i,
  input  logic [NUM_CH*CNT_W-1:0] duty_i,
  output logic [NUM_CH-1:0]       pwm_o,
  output logic [NUM_CH-1:0]       cfg_bad_o
);

  logic rst_n;

  pwm_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk_i   (clk_i),
    .arst_ni (arst_ni),
    .rst_no  (rst_n)
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    logic             ok;
    logic [CNT_W-1:0] hi_len;
    logic [CNT_W-1:0] lo_len;
    logic [CNT_W-1:0] cur_lo;
    logic             load;
    logic             level;
    logic             bad;

    pwm_cfg_check #(.CNT_W(CNT_W)) u_check (
      .period_i (period_i[g*CNT_W +: CNT_W]),
      .duty_i   (duty_i[g*CNT_W +: CNT_W]),
      .ok_o     (ok),
      .hi_len_o (hi_len),
      .lo_len_o (lo_len)
    );

    pwm_cfg_shadow #(.CNT_W(CNT_W)) u_shadow (
      .clk_i     (clk_i),
      .rst_ni    (rst_n),
      .restart_i (ch_restart_i[g]),
      .load_i    (load),
      .new_ok_i  (ok),
      .new_lo_i  (lo_len),
      .cur_lo_o  (cur_lo),
      .bad_o     (bad)
    );

    pwm_phase_cnt #(.CNT_W(CNT_W)) u_phase (
      .clk_i     (clk_i),
      .rst_ni    (rst_n),
      .restart_i (ch_restart_i[g]),
      .new_ok_i  (ok),
      .new_hi_i  (hi_len),
      .cur_lo_i  (cur_lo),
      .load_o    (load),
      .level_o   (level)
    );

    assign pwm_o[g]     = level;
    assign cfg_bad_o[g] = bad;

    // R3: a flagged channel never drives high
    assert_bad_low_R3: assert property (@(posedge clk_i) disable iff (!rst_n)
      cfg_bad_o[g] |-> !pwm_o[g]);
  end

endmodule

// File: tb/pwm_multi_cd_bench.sv
module pwm_multi_cd_bench;

  localparam int NCH = 4;
  localparam int CW  = 16;
  localparam int NVEC = 6;
  // period, duty, expected high run, expected low run
  localparam int VEC [NVEC][4] = '{
    '{10, 3, 3, 7},
    '{8, 4, 4, 4},
    '{5, 1, 1, 4},
    '{7, 6, 6, 1},
    '{2, 1, 1, 1},
    '{23, 9, 9, 14}
  };

  logic              clk = 1'b0;
  logic              arst_n;
  logic [NCH-1:0]    restart;
  logic [NCH*CW-1:0] period;
  logic [NCH*CW-1:0] duty;
  logic [NCH-1:0]    pwm;
  logic [NCH-1:0]    bad;

  int total = 0;
  int fails = 0;
  int cycles = 0;

  always #5 clk = ~clk;

  pwm_multi_cd #(.NUM_CH(NCH), .CNT_W(CW)) u_pwm_multi_cd (
    .clk_i        (clk),
    .arst_ni      (arst_n),
    .ch_restart_i (restart),
    .period_i     (period),
    .duty_i       (duty),
    .pwm_o        (pwm),
    .cfg_bad_o    (bad)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic set_cfg(input int ch, input int p, input int d);
    period[ch*CW +: CW] = CW'(p);
    duty[ch*CW +: CW]   = CW'(d);
  endtask

  // called at a negedge; leaves at the first negedge where the level differs
  task automatic run_len(input int ch, input logic lvl, output int n);
    n = 0;
    while (pwm[ch] === lvl && n < 1000) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic do_restart(input int ch);
    @(negedge clk);
    restart[ch] = 1'b1;
    @(negedge clk);
    restart[ch] = 1'b0;
    @(negedge clk);
  endtask

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", total, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      total++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
      finish_run();
    end
  end

  initial begin
    int hi, lo, n_hi, n_bad;
    arst_n  = 1'b0;
    restart = '0;
    period  = '0;
    duty    = '0;
    set_cfg(0, 4, 2);
    repeat (3) @(negedge clk);
    // R8: reset state
    chk("R8 pwm in reset", int'(pwm), 0);
    chk("R8 cfg_bad in reset", int'(bad), 0);
    arst_n = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk("R8 still low after second edge", int'(pwm[0]), 0);
    @(negedge clk);
    chk("R8 high after third edge", int'(pwm[0]), 1);

    // R1: table of settings, each on its own channel in turn
    for (int i = 0; i < NVEC; i++) begin
      int ch;
      ch = i % NCH;
      set_cfg(ch, VEC[i][0], VEC[i][1]);
      do_restart(ch);
      run_len(ch, 1'b1, hi);
      run_len(ch, 1'b0, lo);
      chk($sformatf("R1 vec%0d high", i), hi, VEC[i][2]);
      chk($sformatf("R1 vec%0d low", i), lo, VEC[i][3]);
      run_len(ch, 1'b1, hi);
      chk($sformatf("R1 vec%0d repeat high", i), hi, VEC[i][2]);
    end

    // R7: restart holds low, first edge after release starts high
    set_cfg(2, 6, 3);
    @(negedge clk);
    restart[2] = 1'b1;
    @(negedge clk);
    chk("R7 low during restart", int'(pwm[2]), 0);
    @(negedge clk);
    chk("R7 still low during restart", int'(pwm[2]), 0);
    restart[2] = 1'b0;
    @(negedge clk);
    chk("R7 high after release", int'(pwm[2]), 1);

    // R5: change mid high phase, old period finishes intact
    set_cfg(0, 10, 3);
    do_restart(0);
    set_cfg(0, 6, 2);
    run_len(0, 1'b1, hi);
    run_len(0, 1'b0, lo);
    chk("R5 old high", hi, 3);
    chk("R5 old low", lo, 7);
    run_len(0, 1'b1, hi);
    run_len(0, 1'b0, lo);
    chk("R5 new high", hi, 2);
    chk("R5 new low", lo, 4);

    // R6: disturb channel 0 while channel 1 is measured
    set_cfg(1, 12, 5);
    do_restart(1);
    set_cfg(0, 9, 8);
    restart[0] = 1'b1;
    run_len(1, 1'b1, hi);
    restart[0] = 1'b0;
    run_len(1, 1'b0, lo);
    chk("R6 ch1 high", hi, 5);
    chk("R6 ch1 low", lo, 7);

    // R4: duty equal to period keeps the output high
    set_cfg(3, 6, 6);
    do_restart(3);
    n_hi = 0;
    for (int k = 0; k < 30; k++) begin
      n_hi += int'(pwm[3]);
      @(negedge clk);
    end
    chk("R4 full high count", n_hi, 30);

    // R3: invalid settings, each checked over a window
    for (int v = 0; v < 3; v++) begin
      case (v)
        0: set_cfg(3, 0, 0);
        1: set_cfg(3, 5, 0);
        default: set_cfg(3, 4, 7);
      endcase
      do_restart(3);
      n_hi = 0;
      n_bad = 0;
      for (int k = 0; k < 20; k++) begin
        n_hi  += int'(pwm[3]);
        n_bad += int'(bad[3]);
        @(negedge clk);
      end
      chk($sformatf("R3 case%0d high cycles", v), n_hi, 0);
      chk($sformatf("R3 case%0d flag cycles", v), n_bad, 20);
    end

    // R9: parked channel resumes on the first valid edge
    set_cfg(3, 4, 1);
    @(negedge clk);
    chk("R9 high on first valid edge", int'(pwm[3]), 1);
    chk("R9 flag cleared", int'(bad[3]), 0);

    // R8: asynchronous assertion mid-run
    #2 arst_n = 1'b0;
    #1;
    chk("R8 async clear pwm", int'(pwm), 0);
    chk("R8 async clear flag", int'(bad), 0);
    @(negedge clk);
    arst_n = 1'b1;
    repeat (3) @(negedge clk);

    finish_run();
  end

endmodule